// File: doc/BRIEF.md
# Receive Character Buffer with Fill Watermark and Idle Aging

This block sits between a serial receiver's deserializer and a host. Each time the deserializer finishes a character it presents the byte together with its framing-error, parity-error and break indications; the block stores it in a 32-entry first-in first-out queue. The host pulls words out through a simple read strobe, and each word carries the byte plus its error flags and an overrun flag.

Three sticky status flags drive a single interrupt line. The first asks for service once the fill level reaches a programmable threshold. The second, an aging flag, asks for service when characters are sitting in the queue and nothing has happened for 8 character periods, so that a short trailing burst below the threshold is not stranded. The third reports a detected line break, at any fill level. Each flag has its own enable, and the host clears flags by writing ones to them.

The deserializer also provides a one-cycle strobe per character period, which paces the aging timer. Baud generation and serial sampling are outside this block.

Top module: `rx_service_fifo`

## Requirements
- R1: Characters are returned in arrival order; a read word holds the byte in bits 7:0, framing error in bit 8, parity error in bit 9, overrun in bit 10 and break in bit 11, valid the cycle after the read strobe.
- R2: `fill_level` gives the number of stored characters, and `data_rdy` is 1 exactly when that number is non-zero, both one cycle after the push or read that changes them.
- R3: Status bit 0 (fill watermark) becomes 1 when the fill level is at or above `rx_thresh`, and stays 0 while the level is below it.
- R4: Status bit 1 (aging) becomes 1 on the 8th character-period strobe after the last push or read, provided the queue is not empty.
- R5: The aging count restarts on every arriving character and every host read, and it is held at zero while the queue is empty, so an empty queue never sets status bit 1.
- R6: Status bit 2 (break) becomes 1 the cycle after `brk_det` pulses, whatever the fill level.
- R7: Writing with `st_clr_we` clears each status bit whose mask bit is 1 and leaves the others; a mask of all ones clears all; a set condition present in the same cycle wins over the clear.
- R8: `irq` is 1 one cycle after any status bit is 1 while the matching bit of `irq_en` is 1.
- R9: A character arriving while 32 characters are stored is dropped, the level stays 32, and the overrun bit of the newest stored entry is set.
- R10: A read while the queue is empty returns an all-zero word and leaves the level unchanged.
- R11: After reset the level is 0, `data_rdy`, `status`, `irq` and `rd_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received character is presented this cycle |
| in_data | input | 8 | Received byte |
| in_frm_err | input | 1 | Framing error of this character |
| in_par_err | input | 1 | Parity error of this character |
| in_brk | input | 1 | Character was a break |
| char_tick | input | 1 | One-cycle strobe per character period |
| brk_det | input | 1 | Line break detected pulse |
| rd_en | input | 1 | Host read strobe |
| rd_word | output | 12 | Read word: byte and flags |
| rx_thresh | input | 6 | Fill watermark threshold |
| irq_en | input | 3 | Enable per status bit |
| st_clr_we | input | 1 | Status clear write strobe |
| st_clr_mask | input | 3 | Ones select status bits to clear |
| fill_level | output | 6 | Number of stored characters |
| data_rdy | output | 1 | At least one character stored |
| status | output | 3 | Sticky flags: 0 watermark, 1 aging, 2 break |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions keep the level within the depth, hold it still when a character arrives into a full queue, keep the aging count at zero on an empty queue and never past its limit, tie the watermark and break flags to their causes, check that a write-one clear takes effect, and keep the interrupt line in step with enabled flags. Read ordering, the per-entry flag layout, the overrun mark landing on the newest entry, and the exact count of eight idle character periods (including the restart after a read) are shown only by the bench's scenarios, where a queue of expected words is compared against each read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int NUM_ST   = 3;
  localparam int ST_RXRDY = 0;
  localparam int ST_AGE   = 1;
  localparam int ST_BRK   = 2;
  // read word layout
  localparam int B_FRM    = 8;
  localparam int B_PAR    = 9;
  localparam int B_OVR    = 10;
  localparam int B_BRK    = 11;
  localparam int WORD_W   = 12;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 32,
  parameter int DW     = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int EW    = DW + 3,
  localparam int OW    = DW + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [EW-1:0] push_entry,   // {brk, par, frm, data}
  input  logic          pop_req,
  output logic [LW-1:0] level,
  output logic          nonempty,
  output logic [OW-1:0] rd_word       // {brk, ovr, par, frm, data}
);
  logic [EW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] ovr_bits;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [EW-1:0] ram_q;
  logic          ovr_q, valid_q;
  logic          empty, full, push_ok, pop_ok;
  logic [LW-1:0] level_n;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop_req && !empty;

  always_comb begin
    level_n = level;
    if (push_ok && !pop_ok) level_n = level + 1'b1;
    else if (!push_ok && pop_ok) level_n = level - 1'b1;
  end

  // storage array: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_entry;
    if (pop_ok)  ram_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      nonempty <= 1'b0;
      ovr_bits <= '0;
      ovr_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      level    <= level_n;
      nonempty <= (level_n != '0);
      if (push_ok) begin
        wr_ptr           <= wr_ptr + 1'b1;
        ovr_bits[wr_ptr] <= 1'b0;
      end else if (push && full) begin
        ovr_bits[wr_ptr - 1'b1] <= 1'b1;
      end
      if (pop_req) begin
        valid_q <= pop_ok;
        ovr_q   <= pop_ok ? ovr_bits[rd_ptr] : 1'b0;
      end
      if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rd_word = valid_q ? {ram_q[EW-1], ovr_q, ram_q[EW-2:0]} : '0;

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop_req) |=> $stable(level));
  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty && !push) |=> (rd_word == '0 && level == '0));
endmodule

// File: rtl/rxq_age.sv
module rxq_age #(
  parameter int AGE_CHARS = 8,
  localparam int CW       = $clog2(AGE_CHARS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic empty,
  input  logic restart,
  output logic hit
);
  logic [CW-1:0] cnt;

  assign hit = tick && !empty && !restart && (cnt == CW'(AGE_CHARS - 1));

  always_ff @(posedge clk) begin
    if (rst || empty || restart) cnt <= '0;
    else if (tick && cnt != CW'(AGE_CHARS)) cnt <= cnt + 1'b1;
  end

  // R5
  age_hold_chk: assert property (@(posedge clk) disable iff (rst)
    empty |=> (cnt == '0));
  // R4
  age_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(AGE_CHARS));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_ST-1:0] set_vec,
  input  logic              clr_we,
  input  logic [NUM_ST-1:0] clr_mask,
  input  logic [NUM_ST-1:0] en,
  output logic [NUM_ST-1:0] stat,
  output logic              irq
);
  for (genvar i = 0; i < NUM_ST; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) stat[i] <= 1'b0;
      else if (set_vec[i]) stat[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) stat[i] <= 1'b0;
    end

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_mask[i] && !set_vec[i]) |=> !stat[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat & en);
  end

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(stat & en))));
endmodule

// File: rtl/rx_service_fifo.sv
module rx_service_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int AGE_CHARS = 8,
  localparam int LW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_frm_err,
  input  logic              in_par_err,
  input  logic              in_brk,
  input  logic              char_tick,
  input  logic              brk_det,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  input  logic [LW-1:0]     rx_thresh,
  input  logic [NUM_ST-1:0] irq_en,
  input  logic              st_clr_we,
  input  logic [NUM_ST-1:0] st_clr_mask,
  output logic [LW-1:0]     fill_level,
  output logic              data_rdy,
  output logic [NUM_ST-1:0] status,
  output logic              irq
);
  logic              age_hit;
  logic [NUM_ST-1:0] set_vec;

  rxq_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk        (clk),
    .rst        (rst),
    .push       (in_valid),
    .push_entry ({in_brk, in_par_err, in_frm_err, in_data}),
    .pop_req    (rd_en),
    .level      (fill_level),
    .nonempty   (data_rdy),
    .rd_word    (rd_word)
  );

  rxq_age #(.AGE_CHARS(AGE_CHARS)) u_age (
    .clk     (clk),
    .rst     (rst),
    .tick    (char_tick),
    .empty   (!data_rdy),
    .restart (in_valid || rd_en),
    .hit     (age_hit)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[ST_RXRDY] = (fill_level >= rx_thresh);
    set_vec[ST_AGE]   = age_hit;
    set_vec[ST_BRK]   = brk_det;
  end

  rxq_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_we   (st_clr_we),
    .clr_mask (st_clr_mask),
    .en       (irq_en),
    .stat     (status),
    .irq      (irq)
  );

  // R6
  brk_flag_chk: assert property (@(posedge clk) disable iff (rst)
    brk_det |=> status[ST_BRK]);
  // R3
  rxrdy_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_level >= rx_thresh) |=> status[ST_RXRDY]);
endmodule

// File: tb/test_rx_service_fifo.sv
module test_rx_service_fifo;
  localparam int DEPTH = 32;
  localparam int LW    = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic in_valid = 0, in_frm_err = 0, in_par_err = 0, in_brk = 0;
  logic [7:0] in_data = '0;
  logic char_tick = 0, brk_det = 0, rd_en = 0, st_clr_we = 0;
  logic [11:0] rd_word;
  logic [LW-1:0] rx_thresh = 6'd4, fill_level;
  logic [2:0] irq_en = '0, st_clr_mask = '0, status;
  logic data_rdy, irq;

  int checks = 0;
  int fails  = 0;
  logic [11:0] exp_q[$];

  rx_service_fifo i_rx_service_fifo (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_frm_err(in_frm_err), .in_par_err(in_par_err), .in_brk(in_brk),
    .char_tick(char_tick), .brk_det(brk_det), .rd_en(rd_en), .rd_word(rd_word),
    .rx_thresh(rx_thresh), .irq_en(irq_en), .st_clr_we(st_clr_we),
    .st_clr_mask(st_clr_mask), .fill_level(fill_level), .data_rdy(data_rdy),
    .status(status), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: presents a character and records the expected read word
  task automatic push_char(logic [7:0] d, logic f, logic p, logic b);
    @(negedge clk);
    in_valid = 1; in_data = d; in_frm_err = f; in_par_err = p; in_brk = b;
    @(negedge clk);
    in_valid = 0; in_frm_err = 0; in_par_err = 0; in_brk = 0;
    if (exp_q.size() < DEPTH) exp_q.push_back({b, 1'b0, p, f, d});
    else exp_q[exp_q.size() - 1][10] = 1'b1;
  endtask

  task automatic host_read();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic tick();
    @(negedge clk); char_tick = 1;
    @(negedge clk); char_tick = 0;
  endtask

  task automatic clear(logic [2:0] m);
    @(negedge clk); st_clr_we = 1; st_clr_mask = m;
    @(negedge clk); st_clr_we = 0; st_clr_mask = '0;
  endtask

  // monitor: compares each read word against the scoreboard queue (R1, R10)
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en && !rst) begin
        logic [11:0] e;
        @(negedge clk);
        e = (exp_q.size() == 0) ? 12'h000 : exp_q.pop_front();
        chk("R1/R10 read word", 32'(rd_word), 32'(e));
      end
    end
  end

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    // R11 reset state
    chk("R11 level", 32'(fill_level), 0);
    chk("R11 data_rdy", 32'(data_rdy), 0);
    chk("R11 status", 32'(status), 0);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 rd_word", 32'(rd_word), 0);

    // R10 read from empty
    host_read(); idle(1);
    chk("R10 level after empty read", 32'(fill_level), 0);

    // R1/R2/R3 mixed flags, threshold 4
    push_char(8'h41, 0, 0, 0);
    push_char(8'h5A, 1, 0, 0);
    push_char(8'hC3, 0, 1, 0);
    push_char(8'h00, 0, 0, 1);
    push_char(8'hFF, 1, 1, 0);
    idle(3);
    chk("R2 level 5", 32'(fill_level), 5);
    chk("R2 data_rdy", 32'(data_rdy), 1);
    chk("R3 watermark set", 32'(status[0]), 1);
    chk("R8 irq disabled", 32'(irq), 0);
    irq_en = 3'b001; idle(2);
    chk("R8 irq enabled", 32'(irq), 1);
    clear(3'b001); idle(1);
    chk("R7 set wins over clear", 32'(status[0]), 1);
    repeat (5) host_read();
    idle(2);
    clear(3'b001); idle(2);
    chk("R7 watermark cleared", 32'(status[0]), 0);
    chk("R8 irq dropped", 32'(irq), 0);
    chk("R2 data_rdy empty", 32'(data_rdy), 0);

    // R3 boundary, R9 overflow
    rx_thresh = 6'd32;
    for (int i = 0; i < 31; i++) push_char(8'(i * 7 + 3), i[0], i[1], 0);
    idle(3);
    chk("R3 below threshold", 32'(status[0]), 0);
    push_char(8'hA5, 0, 0, 0);
    idle(3);
    chk("R3 at threshold", 32'(status[0]), 1);
    push_char(8'h99, 0, 0, 0);
    idle(1);
    chk("R9 level stays full", 32'(fill_level), 32);
    for (int i = 0; i < 32; i++) host_read();
    idle(2);
    chk("R2 drained", 32'(fill_level), 0);
    clear(3'b111); idle(2);
    chk("R7 all-ones clear", 32'(status), 0);

    // R4 aging
    push_char(8'h11, 0, 0, 0);
    push_char(8'h22, 0, 0, 0);
    repeat (7) tick();
    idle(1);
    chk("R4 no aging after 7", 32'(status[1]), 0);
    tick(); idle(1);
    chk("R4 aging after 8", 32'(status[1]), 1);
    clear(3'b010); idle(1);
    // R5 restart by a read
    host_read();
    repeat (7) tick();
    idle(1);
    chk("R5 restart on read", 32'(status[1]), 0);
    tick(); idle(1);
    chk("R5 aging after restart", 32'(status[1]), 1);
    // R6 break, R7 selective clear
    @(negedge clk); brk_det = 1; @(negedge clk); brk_det = 0;
    idle(1);
    chk("R6 break flag", 32'(status), 3'b110);
    clear(3'b010); idle(1);
    chk("R7 selective clear", 32'(status), 3'b100);
    irq_en = 3'b100; idle(2);
    chk("R8 break irq", 32'(irq), 1);
    clear(3'b111); idle(2);
    host_read(); idle(2);
    // R5 empty holds counter
    repeat (12) tick();
    idle(1);
    chk("R5 empty no aging", 32'(status[1]), 0);
    chk("R8 irq idle", 32'(irq), 0);

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule